// File: doc/BRIEF.md
# Phase Current Balancer

This block keeps the load evenly shared across the phases of an interleaved multi-phase buck controller. Each phase delivers a 12-bit unsigned current sample along with a strobe, once per switching cycle, after its sensing has settled. When every active phase has delivered a fresh sample, the block does three things in the same cycle. It divides the summed samples by the number of active phases, which may be two, three or four. It subtracts that average from each phase's own sample to form a signed imbalance error. It then passes each error through a per-phase first-order low-pass filter.

The filtered value is a signed correction for that phase. The block subtracts it from the phase's ramp compare value and clamps the result. The adjusted compare value is what the downstream modulator compares against its sawtooth. The registered average is also presented on its own port, for load-line regulation and overcurrent detection.

Top module: `phase_current_balancer`

## Requirements
- R1: While reset is asserted, and after it is released until the first update, `avg_out` and every correction are zero and each `cmp_out` lane equals its `cmp_in` lane.
- R2: `cfg_nact` selects the active phases: 2'b10 makes phases 0 and 1 active, 2'b01 makes phases 0 to 2 active, and 2'b00 or 2'b11 makes all four active. A strobe on an inactive phase is ignored: it triggers no update and changes no output.
- R3: A phase's sample is latched at the clock edge where its strobe is high. The update takes place at the clock edge one cycle after the edge that latched the last outstanding active sample. `avg_out` and `corr_out` hold their values at every other edge.
- R4: At an update, `avg_out` becomes the sum of the active samples divided by the active count, rounded toward zero. This holds exactly over the whole input range, including the divide-by-three case.
- R5: A phase's error is its latched sample minus the new average, as a 13-bit signed value.
- R6: At an update, each active phase's correction y becomes y + ((e − y) >>> k), where e is the phase's error and k = `flt_k` (0 to 7). The shift is arithmetic and rounds toward minus infinity, so with k = 0 the correction equals the error.
- R7: At an update, the correction of every inactive phase is cleared to zero.
- R8: Each `cmp_out` lane is its `cmp_in` lane minus that phase's correction, clamped to the range 0 to 4095 rather than wrapping. The path is combinational.
- R9: Phases may strobe in different cycles. A second strobe from a phase before the update replaces that phase's earlier sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nact | input | 2 | Active phase count select |
| flt_k | input | 3 | Filter shift amount |
| smp_stb | input | 4 | Per-phase sample strobe |
| smp_val | input | 48 | Per-phase 12-bit samples, phase 0 in the low bits |
| cmp_in | input | 48 | Per-phase 12-bit ramp compare values |
| cmp_out | output | 48 | Per-phase corrected, clamped compare values |
| corr_out | output | 52 | Per-phase 13-bit signed corrections |
| avg_out | output | 12 | Registered average phase current |

## Verification
The bench uses the default 12-bit sample width and four phase slots. At this size, every sum reachable in three-phase mode (0 to 12285) can be swept one value at a time, which exercises the reciprocal-multiply divider at each remainder and at full scale. Pseudo-random rounds in all modes and at all eight filter shifts drive the corrections negative and positive. Extreme compare values are paired with them so that both clamp limits are reached. Directed sequences cover staggered strobes, overwritten samples and strobes on inactive phases.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int NCH = 4;

  typedef enum logic [1:0] {
    NACT_FOUR  = 2'b00,
    NACT_THREE = 2'b01,
    NACT_TWO   = 2'b10,
    NACT_FOURB = 2'b11
  } nact_e;

  function automatic logic [NCH-1:0] nact_mask(input logic [1:0] sel);
    case (nact_e'(sel))
      NACT_TWO:   nact_mask = 4'b0011;
      NACT_THREE: nact_mask = 4'b0111;
      default:    nact_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [2:0] nact_count(input logic [1:0] sel);
    case (nact_e'(sel))
      NACT_TWO:   nact_count = 3'd2;
      NACT_THREE: nact_count = 3'd3;
      default:    nact_count = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pcb_capture.sv
module pcb_capture #(
  parameter int NCH = 4,
  parameter int SW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    act,
  input  logic [NCH-1:0]    stb,
  input  logic [NCH*SW-1:0] din,
  output logic [NCH*SW-1:0] smp,
  output logic              upd
);
  logic [NCH-1:0]    seen_q, seen_d;
  logic [NCH*SW-1:0] smp_q, smp_d;

  always_comb begin
    upd    = ((seen_q & act) == act);
    seen_d = (upd ? '0 : seen_q) | (stb & act);
    smp_d  = smp_q;
    for (int i = 0; i < NCH; i++) begin
      if (stb[i] && act[i]) smp_d[i*SW +: SW] = din[i*SW +: SW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      smp_q  <= '0;
    end else begin
      seen_q <= seen_d;
      smp_q  <= smp_d;
    end
  end

  assign smp = smp_q;
endmodule

// File: rtl/pcb_average.sv
module pcb_average #(
  parameter int NCH = 4,
  parameter int SW  = 12
) (
  input  logic [NCH*SW-1:0] smp,
  input  logic [NCH-1:0]    act,
  input  logic [2:0]        cnt,
  output logic [SW-1:0]     avg
);
  localparam int SUMW  = SW + $clog2(NCH);
  localparam int DSH   = SUMW + 2;
  localparam int PW    = SUMW + DSH;
  localparam int RECIP = ((1 << DSH) + 2) / 3;

  logic [SUMW-1:0] sum;
  logic [PW-1:0]   prod;

  always_comb begin
    sum = '0;
    for (int i = 0; i < NCH; i++) begin
      if (act[i]) sum = sum + SUMW'(smp[i*SW +: SW]);
    end
    prod = PW'(sum) * PW'(RECIP);
    case (cnt)
      3'd2:    avg = SW'(sum >> 1);
      3'd3:    avg = SW'(prod >> DSH);
      default: avg = SW'(sum >> 2);
    endcase
  end
endmodule

// File: rtl/pcb_iir.sv
module pcb_iir #(
  parameter int EW = 13,
  parameter int KW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 clr,
  input  logic signed [EW-1:0] x,
  input  logic [KW-1:0]        k,
  output logic signed [EW-1:0] y
);
  logic signed [EW-1:0] y_q, y_d;
  logic signed [EW:0]   diff, step;

  always_comb begin
    diff = {x[EW-1], x} - {y_q[EW-1], y_q};
    step = diff >>> k;
    y_d  = EW'({y_q[EW-1], y_q} + step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  y_q <= '0;
    else if (en) y_q <= clr ? '0 : y_d;
  end

  assign y = y_q;
endmodule

// File: rtl/pcb_trim.sv
module pcb_trim #(
  parameter int SW = 12,
  parameter int EW = 13
) (
  input  logic [SW-1:0]        cmp,
  input  logic signed [EW-1:0] corr,
  output logic [SW-1:0]        res
);
  localparam int TW = ((SW > EW) ? SW : EW) + 2;
  localparam logic signed [TW-1:0] TOP = TW'((1 << SW) - 1);

  logic signed [TW-1:0] diff;

  always_comb begin
    diff = $signed({{(TW-SW){1'b0}}, cmp}) - $signed({{(TW-EW){corr[EW-1]}}, corr});
    if (diff < 0)        res = '0;
    else if (diff > TOP) res = '1;
    else                 res = SW'(diff);
  end
endmodule

// File: rtl/phase_current_balancer.sv
module phase_current_balancer
  import pcb_pkg::*;
#(
  parameter int SW = 12,
  parameter int KW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_nact,
  input  logic [KW-1:0]       flt_k,
  input  logic [NCH-1:0]      smp_stb,
  input  logic [NCH*SW-1:0]   smp_val,
  input  logic [NCH*SW-1:0]   cmp_in,
  output logic [NCH*SW-1:0]   cmp_out,
  output logic [NCH*(SW+1)-1:0] corr_out,
  output logic [SW-1:0]       avg_out
);
  localparam int EW = SW + 1;

  logic [NCH-1:0]    act;
  logic [2:0]        cnt;
  logic [NCH*SW-1:0] smp;
  logic              upd;
  logic [SW-1:0]     avg_c, avg_q;

  assign act = nact_mask(cfg_nact);
  assign cnt = nact_count(cfg_nact);

  pcb_capture #(.NCH(NCH), .SW(SW)) u_cap (
    .clk(clk), .rst_n(rst_n), .act(act), .stb(smp_stb),
    .din(smp_val), .smp(smp), .upd(upd)
  );

  pcb_average #(.NCH(NCH), .SW(SW)) u_avg (
    .smp(smp), .act(act), .cnt(cnt), .avg(avg_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   avg_q <= '0;
    else if (upd) avg_q <= avg_c;
  end
  assign avg_out = avg_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic signed [EW-1:0] err, corr;
    assign err = EW'($signed({1'b0, smp[g*SW +: SW]}) - $signed({1'b0, avg_c}));

    pcb_iir #(.EW(EW), .KW(KW)) u_iir (
      .clk(clk), .rst_n(rst_n), .en(upd), .clr(!act[g]),
      .x(err), .k(flt_k), .y(corr)
    );

    pcb_trim #(.SW(SW), .EW(EW)) u_trim (
      .cmp(cmp_in[g*SW +: SW]), .corr(corr), .res(cmp_out[g*SW +: SW])
    );

    assign corr_out[g*EW +: EW] = corr;
  end
endmodule

// File: rtl/phase_current_balancer_chk.sv
module phase_current_balancer_chk #(
  parameter int NCH = 4,
  parameter int SW  = 12,
  parameter int KW  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   upd,
  input logic [1:0]             cfg_nact,
  input logic [KW-1:0]          flt_k,
  input logic [NCH*SW-1:0]      cmp_in,
  input logic [NCH*SW-1:0]      cmp_out,
  input logic [NCH*(SW+1)-1:0]  corr_out,
  input logic [SW-1:0]          avg_out
);
  localparam int EW = SW + 1;

  int tot;
  always_comb begin
    tot = 0;
    for (int i = 0; i < NCH; i++) tot += int'($signed(corr_out[i*EW +: EW]));
  end

  a_r3_hold_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(avg_out) && $stable(corr_out)));

  // R4 and R5: with k = 0 the active errors add up to sum mod N, i.e. 0 to N-1.
  a_r4_err_sum_range: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && flt_k == '0) |=> (tot >= 0 && tot <= NCH - 1));

  a_r7_two_clears_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cfg_nact == 2'b10) |=>
      (corr_out[2*EW +: EW] == '0 && corr_out[3*EW +: EW] == '0));

  a_r7_three_clears_last: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cfg_nact == 2'b01) |=> (corr_out[3*EW +: EW] == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_dir
    a_r8_neg_corr_raises: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(corr_out[g*EW +: EW]) <= 0) |-> (cmp_out[g*SW +: SW] >= cmp_in[g*SW +: SW]));
    a_r8_pos_corr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(corr_out[g*EW +: EW]) >= 0) |-> (cmp_out[g*SW +: SW] <= cmp_in[g*SW +: SW]));
  end
endmodule

bind phase_current_balancer phase_current_balancer_chk #(.NCH(pcb_pkg::NCH), .SW(SW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .cfg_nact(cfg_nact), .flt_k(flt_k),
  .cmp_in(cmp_in), .cmp_out(cmp_out), .corr_out(corr_out), .avg_out(avg_out)
);

// File: tb/phase_current_balancer_tb.sv
module phase_current_balancer_tb;
  localparam int SW = 12;
  localparam int EW = 13;
  localparam int N  = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      cfg_nact;
  logic [2:0]      flt_k;
  logic [N-1:0]    smp_stb;
  logic [N*SW-1:0] smp_val;
  logic [N*SW-1:0] cmp_in;
  logic [N*SW-1:0] cmp_out;
  logic [N*EW-1:0] corr_out;
  logic [SW-1:0]   avg_out;

  int n_chk = 0;
  int n_bad = 0;
  int y_m[N];
  int s_m[N];
  int avg_m = 0;
  int lcg = 12345;

  always #5 clk = ~clk;

  phase_current_balancer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_nact(cfg_nact), .flt_k(flt_k),
    .smp_stb(smp_stb), .smp_val(smp_val), .cmp_in(cmp_in),
    .cmp_out(cmp_out), .corr_out(corr_out), .avg_out(avg_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt_of(input logic [1:0] m);
    return (m == 2'b10) ? 2 : (m == 2'b01) ? 3 : 4;
  endfunction

  function automatic int rnd(input int lim);
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return (lcg >> 8) % lim;
  endfunction

  function automatic int clampv(input int v);
    return (v < 0) ? 0 : (v > 4095) ? 4095 : v;
  endfunction

  // model of one update (R4, R5, R6, R7)
  task automatic model_update();
    int n = cnt_of(cfg_nact);
    int sum = 0;
    for (int i = 0; i < n; i++) sum += s_m[i];
    avg_m = sum / n;
    for (int i = 0; i < N; i++) begin
      if (i < n) y_m[i] = y_m[i] + ((s_m[i] - avg_m - y_m[i]) >>> flt_k);
      else       y_m[i] = 0;
    end
  endtask

  task automatic check_outs(input bit with_cmp);
    chk(avg_out == SW'(avg_m), "R4 average", int'(avg_out), avg_m);
    for (int i = 0; i < N; i++)
      chk(int'($signed(corr_out[i*EW +: EW])) == y_m[i], "R5/R6/R7 correction",
          int'($signed(corr_out[i*EW +: EW])), y_m[i]);
    if (with_cmp) begin
      for (int i = 0; i < N; i++) begin
        int c = (rnd(4) == 0) ? 0 : (rnd(4) == 0) ? 4095 : rnd(4096);
        cmp_in[i*SW +: SW] = SW'(c);
      end
      #1;
      for (int i = 0; i < N; i++) begin
        int e = clampv(int'(cmp_in[i*SW +: SW]) - y_m[i]);
        chk(int'(cmp_out[i*SW +: SW]) == e, "R8 clamped compare", int'(cmp_out[i*SW +: SW]), e);
      end
    end
  endtask

  // samples in s_m; stag = one phase per cycle (R9)
  task automatic do_round(input logic [1:0] m, input logic [2:0] k, input bit stag, input bit with_cmp);
    int n = cnt_of(m);
    @(negedge clk);
    cfg_nact = m;
    flt_k = k;
    if (!stag) begin
      for (int i = 0; i < n; i++) begin
        smp_stb[i] = 1'b1;
        smp_val[i*SW +: SW] = SW'(s_m[i]);
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        smp_stb = '0;
        smp_stb[i] = 1'b1;
        smp_val[i*SW +: SW] = SW'(s_m[i]);
        if (i != n - 1) begin
          @(negedge clk);
          // R3: nothing moves before the last active sample is in
          chk(avg_out == SW'(avg_m), "R3 early hold", int'(avg_out), avg_m);
        end
      end
    end
    @(negedge clk);
    smp_stb = '0;
    @(negedge clk);
    model_update();
    check_outs(with_cmp);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin y_m[i] = 0; s_m[i] = 0; end
    rst_n = 1'b0; cfg_nact = 2'b00; flt_k = '0; smp_stb = '0; smp_val = '0;
    cmp_in = {12'd4095, 12'd0, 12'd1234, 12'd77};
    repeat (3) @(negedge clk);
    chk(avg_out == '0, "R1 reset average", int'(avg_out), 0);
    chk(corr_out == '0, "R1 reset corrections", 1, 0);
    chk(cmp_out == cmp_in, "R1 compare passthrough", int'(cmp_out[SW-1:0]), int'(cmp_in[SW-1:0]));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(avg_out == '0 && corr_out == '0, "R1 idle after release", int'(avg_out), 0);

    // R4: every three-phase sum, k = 0
    for (int s = 0; s <= 3 * 4095; s++) begin
      int a = s / 3;
      int r = s % 3;
      s_m[0] = a + (r > 0 ? 1 : 0);
      s_m[1] = a + (r > 1 ? 1 : 0);
      s_m[2] = a;
      s_m[3] = 0;
      do_round(2'b01, 3'd0, 1'b0, 1'b0);
    end

    // random rounds in all modes and shifts
    for (int t = 0; t < 400; t++) begin
      logic [1:0] m = 2'(rnd(4));
      for (int i = 0; i < N; i++) s_m[i] = (rnd(5) == 0) ? 4095 * rnd(2) : rnd(4096);
      do_round(m, 3'(rnd(8)), bit'(rnd(2)), 1'b1);
    end

    // R6: settle at k = 7 against a fixed imbalance
    for (int t = 0; t < 40; t++) begin
      s_m[0] = 4095; s_m[1] = 0; s_m[2] = 100; s_m[3] = 3000;
      do_round(2'b00, 3'd7, 1'b0, 1'b1);
    end

    // R2: strobes on inactive phases in two-phase mode do nothing
    @(negedge clk);
    cfg_nact = 2'b10;
    smp_stb = 4'b1100;
    smp_val = {12'd4000, 12'd3900, 12'd0, 12'd0};
    @(negedge clk);
    smp_stb = '0;
    repeat (3) @(negedge clk);
    chk(avg_out == SW'(avg_m), "R2 inactive strobe ignored (avg)", int'(avg_out), avg_m);
    for (int i = 0; i < N; i++)
      chk(int'($signed(corr_out[i*EW +: EW])) == y_m[i], "R2 inactive strobe ignored (corr)",
          int'($signed(corr_out[i*EW +: EW])), y_m[i]);

    // R9: phase 0 strobes twice before phase 1; the later value wins
    @(negedge clk);
    flt_k = 3'd0;
    smp_stb = 4'b0001; smp_val[SW-1:0] = 12'd10;
    @(negedge clk);
    smp_val[SW-1:0] = 12'd2000;
    @(negedge clk);
    smp_stb = 4'b0010; smp_val[2*SW-1:SW] = 12'd1000;
    @(negedge clk);
    smp_stb = '0;
    @(negedge clk);
    s_m[0] = 2000; s_m[1] = 1000;
    model_update();
    chk(avg_out == 12'd1500, "R9 overwrite average", int'(avg_out), 1500);
    check_outs(1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule